// File: doc/BRIEF.md
# PHY Auxiliary Management Register Bank

This block is a small set of management registers for one Ethernet PHY port. It sits behind a generic register interface with a 5-bit register address, 16-bit write data, and single-cycle read and write strobes. Read data follows the address combinationally. A read has side effects only in the cycle its strobe is high.

Two event counters record receive-error pulses and link-disconnect pulses. Each counter clears when it is read and holds at its all-ones value rather than wrapping.

A power-saving control register holds three control bits:
- a preamble-reduction length select,
- a TX amplitude saving enable,
- a TX drive-current saving enable.

A copy of the mode register at 0x14 keeps only the two bits that qualify preamble reduction. The block exports the qualified preamble decision as decoded outputs.

An index register and a data window give indirect access to auxiliary registers. Index 1 reaches the same storage as the direct power-saving register. Index 4 reaches a 16-bit TX amplitude control register.

Top module: `phy_aux_regbank`

## Requirements
- R1: After reset every register reads 0x0000, and all control outputs, including `tx_amp_level_o`, are 0.
- R2: Address 0x16 is a 16-bit counter. It adds one in each clock cycle where `rx_err_pulse_i` is high and holds at 0xFFFF once it reaches that value.
- R3: Address 0x17 returns an 8-bit disconnect counter in bits 7:0, with bits 15:8 reading 0. The counter adds one for each `link_drop_pulse_i` cycle and holds at 0xFF.
- R4: A read strobe at a counter's address returns the current value and zeroes the counter at that clock edge. If an event pulse for that counter arrives in the same cycle, the counter becomes 1 instead.
- R5: Address 0x1D stores bits 11, 10 and 9; all other bits read 0 and ignore writes.
  - Bit 10 drives `amp_save_en_o`.
  - Bit 9 drives `drv_save_en_o`.
- R6: Address 0x14 stores only bits 11 and 10; all other bits read 0.
- R7: `preamble_cut_en_o` is high exactly when bits 11 and 10 of 0x14 are both 1. While it is high:
  - `preamble_cut12_o` equals bit 11 of 0x1D;
  - `preamble_cut22_o` equals its inverse.
  While it is low, both select outputs are 0.
- R8: Address 0x1F stores a 4-bit index in bits 3:0; bits 15:4 read 0.
- R9: With index 1, the window at 0x1E reads and writes the same storage as 0x1D, using the same bit mask. A change made through either address is visible through the other.
- R10: With index 4, the window at 0x1E reads and writes a 16-bit TX amplitude register whose value drives `tx_amp_level_o`.
- R11: With any index other than 1 or 4, the window reads 0 and writes change no register.
- R12: Addresses other than 0x14, 0x16, 0x17, 0x1D, 0x1E and 0x1F read 0. Writes to 0x16, 0x17 or any of those other addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (clears counters on read) |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| rx_err_pulse_i | input | 1 | Receive-error event pulse |
| link_drop_pulse_i | input | 1 | Link-disconnect event pulse |
| preamble_cut_en_o | output | 1 | Preamble reduction qualified |
| preamble_cut12_o | output | 1 | Qualified 12-bit reduction |
| preamble_cut22_o | output | 1 | Qualified 22-bit reduction |
| amp_save_en_o | output | 1 | TX amplitude saving enable |
| drv_save_en_o | output | 1 | TX drive-current saving enable |
| tx_amp_level_o | output | 16 | TX amplitude control value |

## Verification
Almost every state bit reaches either a port or read data without delay, so a corrupted register is seen in the cycle after it is written.
- A counter that drops or doubles an event shows up in the next read of 0x16 or 0x17.
- A counter that wraps instead of holding shows up once its all-ones value is passed.
- A broken alias shows up as a mismatch between 0x1D and the window in the following cycle.
- A window write that leaks into the wrong storage shows up on `tx_amp_level_o` or the saving-enable outputs one edge after the write.

The bench drives a behavioural model alongside the design and compares read data and every output each cycle, so a divergence is reported in the cycle it appears.

// File: rtl/phy_aux_pkg.sv
package phy_aux_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned RXE_W  = 16;
  localparam int unsigned DSC_W  = 8;

  typedef logic [ADDR_W-1:0] reg_addr_t;
  typedef logic [DATA_W-1:0] reg_data_t;
  typedef logic [IDX_W-1:0]  win_idx_t;

  localparam reg_addr_t ADR_MODE  = 5'h14;
  localparam reg_addr_t ADR_RXERR = 5'h16;
  localparam reg_addr_t ADR_DISC  = 5'h17;
  localparam reg_addr_t ADR_PWR   = 5'h1D;
  localparam reg_addr_t ADR_WDATA = 5'h1E;
  localparam reg_addr_t ADR_WIDX  = 5'h1F;

  localparam reg_data_t MODE_MASK = 16'h0C00;
  localparam reg_data_t PWR_MASK  = 16'h0E00;

  localparam int unsigned PWR_CUT_SEL = 11;
  localparam int unsigned PWR_AMP_EN  = 10;
  localparam int unsigned PWR_DRV_EN  = 9;
  localparam int unsigned MODE_QUAL_A = 11;
  localparam int unsigned MODE_QUAL_B = 10;

  localparam win_idx_t IDX_PWR = 4'd1;
  localparam win_idx_t IDX_AMP = 4'd4;
endpackage

// File: rtl/phy_aux_rst_sync.sv
module phy_aux_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/phy_aux_evt_counter.sv
module phy_aux_evt_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;
  localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | (evt_i & (cnt_q != CNT_MAX));
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_d = evt_i ? CNT_ONE : '0;
    end else if (evt_i && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2 R3: an event below the ceiling adds exactly one
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !clr_i && cnt_q != CNT_MAX) |=> cnt_q == WIDTH'($past(cnt_q) + CNT_ONE));
  // R2 R3: the ceiling holds
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);
  // R4: clear on read, event not lost
  a_r4_clear_read: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == ($past(evt_i) ? CNT_ONE : '0));
  // quiet cycles leave the count alone
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/phy_aux_cfg_regs.sv
module phy_aux_cfg_regs
  import phy_aux_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_i,
  input  reg_addr_t addr_i,
  input  reg_data_t wdata_i,
  output reg_data_t mode_o,
  output reg_data_t pwr_o,
  output win_idx_t  idx_o,
  output reg_data_t amp_o,
  output reg_data_t win_rdata_o
);
  reg_data_t mode_q, mode_d;
  reg_data_t pwr_q,  pwr_d;
  win_idx_t  idx_q,  idx_d;
  reg_data_t amp_q,  amp_d;
  logic      mode_en, pwr_en, idx_en, amp_en;
  logic      win_wr;

  always_comb begin
    win_wr  = wr_i && (addr_i == ADR_WDATA);
    mode_en = wr_i && (addr_i == ADR_MODE);
    idx_en  = wr_i && (addr_i == ADR_WIDX);
    pwr_en  = (wr_i && (addr_i == ADR_PWR)) || (win_wr && (idx_q == IDX_PWR));
    amp_en  = win_wr && (idx_q == IDX_AMP);
    mode_d  = wdata_i & MODE_MASK;
    pwr_d   = wdata_i & PWR_MASK;
    idx_d   = wdata_i[IDX_W-1:0];
    amp_d   = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pwr_q  <= '0;
      idx_q  <= '0;
      amp_q  <= '0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (pwr_en)  pwr_q  <= pwr_d;
      if (idx_en)  idx_q  <= idx_d;
      if (amp_en)  amp_q  <= amp_d;
    end
  end

  always_comb begin
    unique case (idx_q)
      IDX_PWR: win_rdata_o = pwr_q;
      IDX_AMP: win_rdata_o = amp_q;
      default: win_rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign pwr_o  = pwr_q;
  assign idx_o  = idx_q;
  assign amp_o  = amp_q;

  // R9: window write at index 1 lands in the direct register
  a_r9_alias_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == ADR_WDATA && idx_q == IDX_PWR) |=> pwr_q == ($past(wdata_i) & PWR_MASK));
  // R11: writes through reserved indices touch nothing
  a_r11_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == ADR_WDATA && idx_q != IDX_PWR && idx_q != IDX_AMP)
      |=> ($stable(pwr_q) && $stable(amp_q) && $stable(mode_q) && $stable(idx_q)));
  // R5 R6: reserved bits stay clear
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_q & ~PWR_MASK) == '0) && ((mode_q & ~MODE_MASK) == '0));
  // R10: amplitude register follows window writes at index 4
  a_r10_amp_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == ADR_WDATA && idx_q == IDX_AMP) |=> amp_q == $past(wdata_i));
endmodule

// File: rtl/phy_aux_regbank.sv
module phy_aux_regbank
  import phy_aux_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  input  logic        rx_err_pulse_i,
  input  logic        link_drop_pulse_i,
  output logic        preamble_cut_en_o,
  output logic        preamble_cut12_o,
  output logic        preamble_cut22_o,
  output logic        amp_save_en_o,
  output logic        drv_save_en_o,
  output logic [15:0] tx_amp_level_o
);
  logic             rst_n_int;
  logic             rxe_clr, dsc_clr;
  logic [RXE_W-1:0] rxe_cnt;
  logic [DSC_W-1:0] dsc_cnt;
  reg_data_t        mode_r, pwr_r, amp_r, win_rd;
  win_idx_t         idx_r;
  logic             addr_mapped;

  phy_aux_rst_sync #(.STAGES(2)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  assign rxe_clr = reg_rd_i && (reg_addr_i == ADR_RXERR);
  assign dsc_clr = reg_rd_i && (reg_addr_i == ADR_DISC);

  phy_aux_evt_counter #(.WIDTH(RXE_W)) u_rxe_cnt (
    .clk   (clk),
    .rst_n (rst_n_int),
    .evt_i (rx_err_pulse_i),
    .clr_i (rxe_clr),
    .cnt_o (rxe_cnt)
  );

  phy_aux_evt_counter #(.WIDTH(DSC_W)) u_dsc_cnt (
    .clk   (clk),
    .rst_n (rst_n_int),
    .evt_i (link_drop_pulse_i),
    .clr_i (dsc_clr),
    .cnt_o (dsc_cnt)
  );

  phy_aux_cfg_regs u_cfg (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .mode_o      (mode_r),
    .pwr_o       (pwr_r),
    .idx_o       (idx_r),
    .amp_o       (amp_r),
    .win_rdata_o (win_rd)
  );

  always_comb begin
    addr_mapped = 1'b1;
    unique case (reg_addr_i)
      ADR_MODE:  reg_rdata_o = mode_r;
      ADR_RXERR: reg_rdata_o = DATA_W'(rxe_cnt);
      ADR_DISC:  reg_rdata_o = DATA_W'(dsc_cnt);
      ADR_PWR:   reg_rdata_o = pwr_r;
      ADR_WDATA: reg_rdata_o = win_rd;
      ADR_WIDX:  reg_rdata_o = DATA_W'(idx_r);
      default: begin
        reg_rdata_o = '0;
        addr_mapped = 1'b0;
      end
    endcase
  end

  always_comb begin
    preamble_cut_en_o = mode_r[MODE_QUAL_A] & mode_r[MODE_QUAL_B];
    preamble_cut12_o  = preamble_cut_en_o &  pwr_r[PWR_CUT_SEL];
    preamble_cut22_o  = preamble_cut_en_o & ~pwr_r[PWR_CUT_SEL];
    amp_save_en_o     = pwr_r[PWR_AMP_EN];
    drv_save_en_o     = pwr_r[PWR_DRV_EN];
    tx_amp_level_o    = amp_r;
  end

  // R12: unmapped reads return zero
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n_int)
    !addr_mapped |-> reg_rdata_o == '0);
  // R7: the two length selects are exclusive and need qualification
  a_r7_cut_exclusive: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0({preamble_cut12_o, preamble_cut22_o}) &&
    ((preamble_cut12_o || preamble_cut22_o) == preamble_cut_en_o));
  // R3: disconnect readback upper byte is zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n_int)
    (reg_addr_i == ADR_DISC) |-> reg_rdata_o[15:8] == 8'h00);
endmodule

// File: tb/tb_phy_aux_regbank.sv
`timescale 1ns/1ps
module tb_phy_aux_regbank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr, rd, rxe, dsc;
  logic [4:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        cut_en, cut12, cut22, amp_en, drv_en;
  logic [15:0] amp_lvl;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  int m_rxe, m_dsc, m_mode, m_pwr, m_idx, m_amp;

  always #5 clk = ~clk;

  phy_aux_regbank dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rx_err_pulse_i(rxe),
    .link_drop_pulse_i(dsc), .preamble_cut_en_o(cut_en), .preamble_cut12_o(cut12),
    .preamble_cut22_o(cut22), .amp_save_en_o(amp_en), .drv_save_en_o(drv_en),
    .tx_amp_level_o(amp_lvl)
  );

  function automatic int mdl_read(int a);
    case (a)
      'h14: return m_mode;
      'h16: return m_rxe;
      'h17: return m_dsc;
      'h1D: return m_pwr;
      'h1E: return (m_idx == 1) ? m_pwr : ((m_idx == 4) ? m_amp : 0);
      'h1F: return m_idx;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_outputs();
    bit en;
    en = ((m_mode >> 11) & 1) && ((m_mode >> 10) & 1);
    chk("cut_en", int'(cut_en), int'(en));
    chk("cut12", int'(cut12), int'(en && ((m_pwr >> 11) & 1)));
    chk("cut22", int'(cut22), int'(en && !((m_pwr >> 11) & 1)));
    chk("amp_save", int'(amp_en), (m_pwr >> 10) & 1);
    chk("drv_save", int'(drv_en), (m_pwr >> 9) & 1);
    chk("amp_level", int'(amp_lvl), m_amp);
  endtask

  task automatic step(bit w, bit r, int a, int d, bit e_rx, bit e_dc);
    @(negedge clk);
    wr = w; rd = r; addr = 5'(a); wdata = 16'(d); rxe = e_rx; dsc = e_dc;
    #1;
    chk("rdata", int'(rdata), mdl_read(a));
    chk_outputs();
    @(posedge clk);
    if (r && a == 'h16) m_rxe = e_rx ? 1 : 0;
    else if (e_rx && m_rxe < 65535) m_rxe++;
    if (r && a == 'h17) m_dsc = e_dc ? 1 : 0;
    else if (e_dc && m_dsc < 255) m_dsc++;
    if (w) begin
      case (a)
        'h14: m_mode = d & 'h0C00;
        'h1D: m_pwr  = d & 'h0E00;
        'h1E: begin
          if (m_idx == 1) m_pwr = d & 'h0E00;
          else if (m_idx == 4) m_amp = d & 'hFFFF;
        end
        'h1F: m_idx = d & 'hF;
        default: ;
      endcase
    end
  endtask

  task automatic wr_reg(int a, int d); step(1, 0, a, d, 0, 0); endtask
  task automatic rd_reg(int a);        step(0, 1, a, 0, 0, 0); endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_rxe = 0; m_dsc = 0; m_mode = 0; m_pwr = 0; m_idx = 0; m_amp = 0;
    wr = 0; rd = 0; addr = '0; wdata = '0; rxe = 0; dsc = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    chk_outputs();
    chk("rdata_reset", int'(rdata), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1: every register reads zero
    for (int a = 0; a < 32; a++) step(0, 0, a, 0, 0, 0);

    // R2: receive-error counting, then clear on read
    tag = "R2";
    for (int i = 0; i < 5; i++) step(0, 0, 'h16, 0, 1, 0);
    step(0, 0, 'h16, 0, 0, 0);
    rd_reg('h16);
    rd_reg('h16);
    // R4: event during the clearing read restarts at 1
    tag = "R4";
    for (int i = 0; i < 3; i++) step(0, 0, 'h10, 0, 1, 1);
    step(0, 1, 'h16, 0, 1, 0);
    step(0, 1, 'h17, 0, 0, 1);
    rd_reg('h16);
    rd_reg('h17);
    rd_reg('h17);
    // R3: disconnect counter saturates at 0xFF, upper byte zero
    tag = "R3";
    for (int i = 0; i < 260; i++) step(0, 0, 'h17, 0, 0, 1);
    rd_reg('h17);
    // R12: writes to the counters change nothing
    tag = "R12";
    for (int i = 0; i < 4; i++) step(0, 0, 'h10, 0, 1, 1);
    wr_reg('h16, 'hABCD);
    wr_reg('h17, 'h1234);
    step(0, 0, 'h16, 0, 0, 0);
    step(0, 0, 'h17, 0, 0, 0);
    rd_reg('h16);
    rd_reg('h17);
    // R2: receive-error counter saturates at 0xFFFF
    tag = "R2";
    for (int i = 0; i < 65540; i++) step(0, 0, 'h16, 0, 1, 0);
    rd_reg('h16);
    step(0, 0, 'h16, 0, 0, 0);

    // R5: power-saving register mask
    tag = "R5";
    wr_reg('h1D, 'hFFFF);
    step(0, 0, 'h1D, 0, 0, 0);
    wr_reg('h1D, 'h0400);
    wr_reg('h1D, 'h0200);
    step(0, 0, 'h1D, 0, 0, 0);
    // R6: mode copy mask
    tag = "R6";
    wr_reg('h14, 'hFFFF);
    step(0, 0, 'h14, 0, 0, 0);
    // R7: qualification and length select
    tag = "R7";
    wr_reg('h1D, 'h0800);
    step(0, 0, 'h1D, 0, 0, 0);
    wr_reg('h1D, 'h0000);
    step(0, 0, 'h1D, 0, 0, 0);
    wr_reg('h14, 'h0800);
    step(0, 0, 'h14, 0, 0, 0);
    wr_reg('h1D, 'h0800);
    wr_reg('h14, 'h0400);
    step(0, 0, 'h14, 0, 0, 0);
    wr_reg('h14, 'h0C00);
    step(0, 0, 'h14, 0, 0, 0);

    // R8: index register width
    tag = "R8";
    wr_reg('h1F, 'hFFFF);
    step(0, 0, 'h1F, 0, 0, 0);
    // R9: alias in both directions
    tag = "R9";
    wr_reg('h1F, 1);
    wr_reg('h1E, 'hF7FF);
    step(0, 0, 'h1D, 0, 0, 0);
    wr_reg('h1D, 'h0A00);
    step(0, 0, 'h1E, 0, 0, 0);
    // R10: amplitude register via index 4
    tag = "R10";
    wr_reg('h1F, 4);
    wr_reg('h1E, 'hA5C3);
    step(0, 0, 'h1E, 0, 0, 0);
    step(0, 0, 'h1D, 0, 0, 0);
    // R11: reserved indices read zero and drop writes
    tag = "R11";
    foreach (m_idx_list[k]) begin
      wr_reg('h1F, m_idx_list[k]);
      wr_reg('h1E, 'hFFFF);
      step(0, 0, 'h1E, 0, 0, 0);
    end
    wr_reg('h1F, 4);
    step(0, 0, 'h1E, 0, 0, 0);
    wr_reg('h1F, 1);
    step(0, 0, 'h1E, 0, 0, 0);
    // R12: unmapped addresses read zero and ignore writes
    tag = "R12";
    wr_reg('h00, 'hFFFF);
    wr_reg('h1C, 'hFFFF);
    for (int a = 0; a < 32; a++) step(0, 0, a, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int m_idx_list[4] = '{0, 2, 3, 15};
endmodule